// File: doc/BRIEF.md
# Continuous Burst Read Engine

This block sequences continuous burst reads out of a synchronous flash array. The host applies a start address while pulsing an address-valid strobe low. The engine then holds a ready output low for a programmable number of clocks and afterwards presents one 16-bit word on each clock, stepping the address upward. The burst has no length limit. It rolls over from the top word of the array to word zero, and it pauses for a fixed number of stall clocks whenever the address moves into a new 128-word line.

Each bank is a fixed slice of the address space, selected by the top address bits, and has a busy input that shows a program or erase is in progress. When the burst steps into a busy bank, or starts in one, the engine freezes the address, ignores further clocks and drives a status word in place of data. Reading restarts only when the host supplies a new address. Raising chip enable or asserting reset ends any burst. The array is behavioural: the word stored at an address is computed from the address.

Top module: `burst_read_engine`

## Requirements
- R1: While `rdy` is high and no new address is latched, each clock presents the word at the next higher address, with `rdy` staying high.
- R2: The word after address 2^ADDR_W-1 is address 0. That step is also a line crossing, so R5 applies to it.
- R3: Reset low, or `ce_n` high at a clock edge, forces `rdy`=0, `stat`=0 and `dout`=0 from the next cycle onward. The engine stays idle until a new address is latched with `ce_n` low.
- R4: `avd_n` sampled low while `ce_n` is low latches `addr`. This aborts any burst, stall or status output that is in progress, and the burst restarts from the new address.
- R5: When the next address has its low 7 bits all zero (a 128-word line boundary), `rdy` is low for BND_PEN cycles before that word appears. BND_PEN defaults to 2.
- R6: If the start address, or the next address, lies in a bank whose `bank_busy` bit is set, then from the following cycle `stat`=1, `rdy`=0 and `dout`=16'hB000 plus the bank number. The bank number is address bits [ADDR_W-1:ADDR_W-log2(NBANKS)].
- R7: Status output persists after the busy bit clears. Only a new `avd_n` latch resumes reading.
- R8: After a latch edge, `rdy` is low for L cycles and the first word appears in cycle L. L is `lat_cfg`, with values 0 and 1 treated as 2, so L ranges from 2 to 7.
- R9: The data word for address A is (A mod 2^16) XOR (A >> 16) XOR 16'hC3A5.
- R10: `rdy` and `stat` are never high together. `dout` is 0 whenever both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| addr | input | ADDR_W | Start address, sampled with `avd_n` |
| lat_cfg | input | 3 | Initial latency setting |
| bank_busy | input | NBANKS | Busy flag for each bank |
| dout | output | 16 | Data or status word |
| rdy | output | 1 | High on clocks that carry valid data |
| stat | output | 1 | High while a status word is driven |

## Verification
Counting the latch edge as edge 0, the first word is due right after edge L. A word that follows a line crossing is due BND_PEN+1 edges after the previous word. The status word, and the idle outputs after `ce_n` rises, are due one edge after their cause. The bench drives inputs and samples outputs on falling edges. After each latch it walks one falling edge at a time, and it expects exactly L low-`rdy` samples and then each word or stall in order. This leaves no slack in which an off-by-one latency or stall count could hide.

// File: rtl/brd_pkg.sv
package brd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DATA, ST_STAT} brd_state_e;

  localparam logic [15:0] WORD_SEED = 16'hC3A5;
  localparam logic [7:0]  STAT_TAG  = 8'hB0;

  // behavioural array content: fold the address in 16-bit slices
  function automatic logic [15:0] fold_word(input logic [63:0] a);
    return a[15:0] ^ a[31:16] ^ a[47:32] ^ a[63:48] ^ WORD_SEED;
  endfunction

  // initial latency setting, floor of two clocks
  function automatic logic [2:0] clamp_lat(input logic [2:0] c);
    return (c < 3'd2) ? 3'd2 : c;
  endfunction
endpackage

// File: rtl/brd_wait_ctr.sv
module brd_wait_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (load)                      cnt <= load_val;
    else if (tick && cnt > CNT_W'(1))   cnt <= cnt - CNT_W'(1);
  end

  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/brd_addr_step.sv
module brd_addr_step #(
  parameter int ADDR_W     = 23,
  parameter int LINE_WORDS = 128,
  parameter int BANK_BITS  = 4
) (
  input  logic [ADDR_W-1:0]    cur,
  output logic [ADDR_W-1:0]    nxt,
  output logic                 line_cross,
  output logic                 wrap,
  output logic [BANK_BITS-1:0] nxt_bank
);
  localparam int LINE_BITS = $clog2(LINE_WORDS);

  assign nxt        = cur + ADDR_W'(1);
  assign line_cross = (nxt[LINE_BITS-1:0] == '0);
  assign wrap       = (cur == {ADDR_W{1'b1}});
  assign nxt_bank   = nxt[ADDR_W-1 -: BANK_BITS];
endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
  import brd_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int NBANKS     = 16,
  parameter int LINE_WORDS = 128,
  parameter int BND_PEN    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              avd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        lat_cfg,
  input  logic [NBANKS-1:0] bank_busy,
  output logic [15:0]       dout,
  output logic              rdy,
  output logic              stat
);
  localparam int BANK_BITS = (NBANKS > 1) ? $clog2(NBANKS) : 1;
  localparam int PEN_BITS  = $clog2(BND_PEN + 1);
  localparam int CNT_W     = (PEN_BITS > 3) ? PEN_BITS : 3;
  localparam bit HAS_PEN   = (BND_PEN > 0);

  brd_state_e           state;
  logic [ADDR_W-1:0]    cur_addr;
  logic [BANK_BITS-1:0] stat_bank;

  logic [ADDR_W-1:0]    nxt_addr;
  logic                 line_cross;
  logic                 ev_wrap;
  logic [BANK_BITS-1:0] nxt_bank;
  logic [BANK_BITS-1:0] start_bank;
  logic                 start_busy;
  logic                 ctr_last;
  logic                 ctr_load;
  logic [CNT_W-1:0]     ctr_val;

  // named events for the checker
  logic ev_take;        // address strobe accepted
  logic ev_latch;       // accepted and bank free: latency starts
  logic ev_step;        // data word advances
  logic ev_busy_hit;    // next word lies in a busy bank
  logic ev_cross_stall; // line crossing with stall cycles

  brd_addr_step #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .BANK_BITS(BANK_BITS)
  ) u_step (
    .cur(cur_addr), .nxt(nxt_addr), .line_cross(line_cross),
    .wrap(ev_wrap), .nxt_bank(nxt_bank)
  );

  assign start_bank     = addr[ADDR_W-1 -: BANK_BITS];
  assign start_busy     = bank_busy[start_bank];
  assign ev_take        = !ce_n && !avd_n;
  assign ev_latch       = ev_take && !start_busy;
  assign ev_step        = !ce_n && avd_n && (state == ST_DATA);
  assign ev_busy_hit    = ev_step && bank_busy[nxt_bank];
  assign ev_cross_stall = ev_step && !bank_busy[nxt_bank] && line_cross && HAS_PEN;

  assign ctr_load = ev_latch || ev_cross_stall;
  assign ctr_val  = ev_latch ? CNT_W'(clamp_lat(lat_cfg)) : CNT_W'(BND_PEN);

  brd_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ctr_val),
    .tick(state == ST_WAIT), .last(ctr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      stat_bank <= '0;
    end else if (ce_n) begin
      state <= ST_IDLE;
    end else if (!avd_n) begin
      cur_addr <= addr;
      if (start_busy) begin
        state     <= ST_STAT;
        stat_bank <= start_bank;
      end else begin
        state <= ST_WAIT;
      end
    end else begin
      case (state)
        ST_WAIT: if (ctr_last) state <= ST_DATA;
        ST_DATA: begin
          cur_addr <= nxt_addr;
          if (ev_busy_hit) begin
            state     <= ST_STAT;
            stat_bank <= nxt_bank;
          end else if (ev_cross_stall) begin
            state <= ST_WAIT;
          end
        end
        default: state <= state; // idle and status hold until a new strobe
      endcase
    end
  end

  assign rdy  = (state == ST_DATA);
  assign stat = (state == ST_STAT);

  always_comb begin
    if (rdy)       dout = fold_word(64'(cur_addr));
    else if (stat) dout = {STAT_TAG, 8'(stat_bank)};
    else           dout = '0;
  end
endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              avd_n,
  input logic              rdy,
  input logic              stat,
  input logic [15:0]       dout,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              ev_latch,
  input logic              ev_busy_hit,
  input logic              ev_cross_stall,
  input logic              ev_wrap
);
  always_comb begin
    if (rst_n) begin
      AST_RDY_STAT_EXCL: assert (!(rdy && stat)); // R10
      AST_IDLE_DOUT_ZERO: assert (rdy || stat || dout == 16'h0); // R10
    end
  end

  AST_CE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!rdy && !stat)); // R3

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !ce_n && avd_n && !ev_busy_hit && !ev_cross_stall)
    |=> (rdy && cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'(1)))); // R1

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && ev_wrap && !ce_n && avd_n && !ev_busy_hit)
    |=> (cur_addr == '0)); // R2

  AST_CROSS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cross_stall |=> !rdy); // R5

  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy_hit |=> (stat && !rdy)); // R6

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !ce_n && avd_n) |=> stat); // R7

  AST_LATCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch |=> (!rdy && !stat)); // R8
endmodule

bind burst_read_engine brd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd_n(avd_n), .rdy(rdy),
  .stat(stat), .dout(dout), .cur_addr(cur_addr), .ev_latch(ev_latch),
  .ev_busy_hit(ev_busy_hit), .ev_cross_stall(ev_cross_stall),
  .ev_wrap(ev_wrap)
);

// File: tb/sim_burst_read_engine.sv
`timescale 1ns/1ps
module sim_burst_read_engine;
  localparam int AW = 23;
  localparam int NB = 16;
  localparam int PEN = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          avd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [2:0]    lat_cfg = 3'd2;
  logic [NB-1:0] bank_busy = '0;
  logic [15:0]   dout;
  logic          rdy;
  logic          stat;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  burst_read_engine #(.ADDR_W(AW), .NBANKS(NB), .LINE_WORDS(128), .BND_PEN(PEN)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd_n(avd_n), .addr(addr),
    .lat_cfg(lat_cfg), .bank_busy(bank_busy), .dout(dout), .rdy(rdy), .stat(stat)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // R9: expected word, written as arithmetic
  function automatic logic [15:0] exp_word(input int unsigned a);
    return 16'((a % 65536) ^ (a / 65536) ^ 32'hC3A5);
  endfunction

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic latch(input int unsigned a, input logic [2:0] cfg);
    @(negedge clk);
    ce_n = 1'b0; avd_n = 1'b0; addr = AW'(a); lat_cfg = cfg;
    @(negedge clk);
    avd_n = 1'b1;
  endtask

  task automatic expect_wait(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, {stat, rdy}, 0);
      @(negedge clk);
    end
  endtask

  task automatic expect_word(input int unsigned a, input string req);
    chk(req, {rdy, dout}, {1'b1, exp_word(a)});
    @(negedge clk);
  endtask

  task automatic expect_status(input int bank, input string req);
    chk(req, {stat, rdy, dout}, {2'b10, 16'hB000 | 16'(bank)});
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R3 reset rdy/stat", {stat, rdy}, 0);
    chk("R3 reset dout", dout, 0);
  endtask

  task automatic t_latency;
    for (int c = 0; c < 8; c++) begin
      int lat = (c < 2) ? 2 : c;
      latch(32'h1234 + c * 16, 3'(c));
      expect_wait(lat, "R8 initial latency");
      expect_word(32'h1234 + c * 16, "R8 first word");
      expect_word(32'h1235 + c * 16, "R1 next word");
    end
  endtask

  task automatic t_line_cross;
    latch(32'h17E, 3'd3);
    expect_wait(3, "R8 latency");
    expect_word(32'h17E, "R9 word");
    expect_word(32'h17F, "R1 word");
    expect_wait(PEN, "R5 line stall");
    expect_word(32'h180, "R5 word after cross");
    expect_word(32'h181, "R1 word");
  endtask

  task automatic t_wrap;
    latch(32'h7FFFFE, 3'd2);
    expect_wait(2, "R8 latency");
    expect_word(32'h7FFFFE, "R1 word");
    expect_word(32'h7FFFFF, "R1 top word");
    expect_wait(PEN, "R2 wrap stall");
    expect_word(0, "R2 wrapped word");
    expect_word(1, "R2 after wrap");
  endtask

  task automatic t_busy_next;
    bank_busy = 16'h0002;
    latch(32'h7FFFE, 3'd2);
    expect_wait(2, "R8 latency");
    expect_word(32'h7FFFE, "R1 word");
    expect_word(32'h7FFFF, "R1 last before busy");
    for (int i = 0; i < 4; i++) expect_status(1, "R6 busy next bank");
    bank_busy = '0;
    for (int i = 0; i < 4; i++) expect_status(1, "R7 status held after release");
    latch(32'h80000, 3'd2);
    expect_wait(2, "R7 resume latency");
    expect_word(32'h80000, "R7 resumed word");
  endtask

  task automatic t_busy_start;
    bank_busy = 16'h0008;
    latch(32'h180010, 3'd4);
    expect_status(3, "R6 busy start bank");
    expect_status(3, "R6 status holds");
    bank_busy = '0;
  endtask

  task automatic t_abort;
    latch(32'h200, 3'd4);
    expect_wait(4, "R8 latency");
    expect_word(32'h200, "R1 word");
    expect_word(32'h201, "R1 word");
    latch(32'h5555, 3'd2);
    expect_wait(2, "R4 abort restarts latency");
    expect_word(32'h5555, "R4 new start word");
    expect_word(32'h5556, "R4 new burst continues");
  endtask

  task automatic t_ce_end;
    latch(32'h300, 3'd2);
    expect_wait(2, "R8 latency");
    expect_word(32'h300, "R1 word");
    ce_n = 1'b1;
    @(negedge clk);
    chk("R3 ce high ends burst", {stat, rdy, dout}, 0);
    ce_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 stays idle without strobe", {stat, rdy, dout}, 0);
    end
  endtask

  task automatic t_reset_mid;
    latch(32'h400, 3'd2);
    expect_wait(2, "R8 latency");
    expect_word(32'h400, "R1 word");
    rst_n = 1'b0;
    #1;
    chk("R3 reset ends burst", {stat, rdy, dout}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 idle after reset", {stat, rdy, dout}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_line_cross();
    t_wrap();
    t_busy_next();
    t_busy_start();
    t_abort();
    t_ce_end();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule